// File: doc/BRIEF.md
# Peripheral Bus Window Router with Local Interrupt Bank

This block sits at the head of an on-chip peripheral bus segment and steers each 32-bit access into one of five fixed address windows. Three windows lead to downstream targets: a host-controller register file, an I/O space and a memory space. The firmware window reaches the memory target as well, so two ranges of the bus address space land on one backing store. For every forwarded access the block removes the window base, presents the relative offset to the selected target and waits for that target's acknowledge. A fifth window holds the bus master's own interrupt registers: status, mask, polarity and a view of the raw interrupt lines. These registers drive one combined interrupt output.

Only one access is in flight at a time. An access that falls outside every window, or one that breaks the shape rules of a register window, is answered with an error and all-ones data and never leaves the block. Register data is big-endian: the byte at the lowest address occupies bits 31:24.

Top module: `opb_window_router`

## Requirements
- R1: An accepted access in 0xC0012000..0xC0012FFF selects the host-controller target (tgt_sel 3'b001). An access in 0xD0010000..0xD001FFFF selects the I/O target (tgt_sel 3'b010). In both cases tgt_offset is the address minus the window base, and tgt_write, tgt_size and tgt_wdata carry the request's values.
- R2: An access in 0xE0010000..0xF000FFFF and one in 0xF0000000..0xFFFFFFFF both select the memory target (tgt_sel 3'b100). Where these two ranges overlap the firmware window wins, so the offset is the address minus 0xF0000000. Otherwise the offset is the address minus 0xE0010000.
- R3: An accepted access outside all five windows is answered with rsp_err=1 and rsp_rdata=0xFFFFFFFF in the cycle after acceptance, and no tgt_sel bit rises.
- R4: req_size encodes 0 as 1 byte, 1 as 2 bytes and 2 as 4 bytes. An access to the local window (0xC0010000..0xC0011FFF) or the host-controller window must be 4 bytes with addr[1:0]=0. If it is not, it gets the R3 error answer and is not forwarded.
- R5: Requests are accepted only while req_ready=1, and req_ready stays low until the response has been given. tgt_sel and tgt_offset hold until the selected target raises its tgt_ack bit; acks from other targets are ignored. In the next cycle rsp_valid pulses once, carrying that target's tgt_rdata lane and tgt_err bit.
- R6: Local offset 0x54 (mask) and local offset 0x58 (polarity) are read/write and reset to 0. Local writes answer with data 0.
- R7: Local offset 0x5C reads irq_raw as sampled one clock earlier. Writes to it change nothing.
- R8: A status bit (local offset 0x50) is set in every cycle in which the sampled raw bit XOR its polarity bit is 1, and it stays set afterwards. A write of 1 to a bit clears it, unless the set condition is still present. Bit 11 (0x00000800) carries the host-controller interrupt line.
- R9: irq_out is 1 exactly when some status bit and the matching mask bit are both 1.
- R10: Any other offset in the local window reads 0xFFFFFFFF without error, and writes to it change no register.
- R11: An access answered locally (local window or error) has rsp_valid in the cycle after acceptance.
- R12: After reset: req_ready=1, rsp_valid=0, tgt_sel=0 and irq_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | 32 | Bus byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | 32 | Response read data |
| tgt_sel | output | 3 | One-hot target select: bit0 host ctrl, bit1 I/O, bit2 memory |
| tgt_write | output | 1 | Forwarded direction |
| tgt_size | output | 2 | Forwarded size code |
| tgt_offset | output | 28 | Offset within the window |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_ack | input | 3 | Per-target completion |
| tgt_err | input | 3 | Per-target error, valid with ack |
| tgt_rdata | input | 96 | Per-target read data, lane i in bits 32*i+31:32*i |
| irq_raw | input | 32 | Raw interrupt lines |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
A bad decode shows on the very next edge. Either the wrong tgt_sel bit rises, or the offset is wrong, or an error pulse comes one cycle after acceptance in place of a forward, so each window edge and the firmware/memory overlap are probed at their limits. A corrupted status, mask or polarity bit stays hidden until the register is read back or the mask lets it reach irq_out; the bench therefore reads each register right after every change. Spurious acknowledges and errors on unselected target lanes are driven during every wait, so a wrong response mux shows in the data of the same response.

// File: rtl/opbr_pkg.sv
package opbr_pkg;

  typedef enum logic [2:0] {
    DST_NONE  = 3'd0,
    DST_LOCAL = 3'd1,
    DST_HC    = 3'd2,
    DST_IO    = 3'd3,
    DST_MEM   = 3'd4
  } opbr_dst_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_RESP = 2'd2
  } opbr_state_e;

  // forwarded target lanes
  localparam int NUM_FWD  = 3;
  localparam int LANE_HC  = 0;
  localparam int LANE_IO  = 1;
  localparam int LANE_MEM = 2;

  // window indices in the decoder
  localparam int NUM_WIN  = 5;
  localparam int WIN_LOC  = 0;
  localparam int WIN_HC   = 1;
  localparam int WIN_IO   = 2;
  localparam int WIN_MEM  = 3;
  localparam int WIN_FW   = 4;

  // size codes
  localparam logic [1:0] SZ_1B = 2'd0;
  localparam logic [1:0] SZ_2B = 2'd1;
  localparam logic [1:0] SZ_4B = 2'd2;

  // local register offsets
  localparam logic [12:0] OFS_STAT = 13'h050;
  localparam logic [12:0] OFS_MASK = 13'h054;
  localparam logic [12:0] OFS_POL  = 13'h058;
  localparam logic [12:0] OFS_RAW  = 13'h05C;

endpackage

// File: rtl/opbr_rst_sync.sv
module opbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/opbr_decode.sv
module opbr_decode
  import opbr_pkg::*;
#(
  parameter int              AW       = 32,
  parameter int              OFF_W    = 28,
  parameter logic [AW-1:0]   LOC_BASE = 32'hC001_0000,
  parameter logic [AW:0]     LOC_SPAN = 33'h0000_2000,
  parameter logic [AW-1:0]   HC_BASE  = 32'hC001_2000,
  parameter logic [AW:0]     HC_SPAN  = 33'h0000_1000,
  parameter logic [AW-1:0]   IO_BASE  = 32'hD001_0000,
  parameter logic [AW:0]     IO_SPAN  = 33'h0001_0000,
  parameter logic [AW-1:0]   MEM_BASE = 32'hE001_0000,
  parameter logic [AW:0]     MEM_SPAN = 33'h1000_0000,
  parameter logic [AW-1:0]   FW_BASE  = 32'hF000_0000,
  parameter logic [AW:0]     FW_SPAN  = 33'h1000_0000
) (
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       size,
  output opbr_dst_e        dst,
  output logic [OFF_W-1:0] off
);
  localparam logic [AW:0] WBASE [NUM_WIN] = '{
    {1'b0, LOC_BASE}, {1'b0, HC_BASE}, {1'b0, IO_BASE},
    {1'b0, MEM_BASE}, {1'b0, FW_BASE}};
  localparam logic [AW:0] WSPAN [NUM_WIN] = '{
    LOC_SPAN, HC_SPAN, IO_SPAN, MEM_SPAN, FW_SPAN};

  logic [NUM_WIN-1:0] hit;
  logic [OFF_W-1:0]   win_off [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [AW:0] rel;
    assign rel        = {1'b0, addr} - WBASE[w];
    assign hit[w]     = !rel[AW] && (rel < WSPAN[w]);
    assign win_off[w] = rel[OFF_W-1:0];
  end

  opbr_dst_e        raw_dst;
  logic [OFF_W-1:0] raw_off;
  logic             reg_win;
  logic             bad_shape;

  // firmware window outranks the memory window where they overlap
  always_comb begin
    raw_dst = DST_NONE;
    raw_off = '0;
    if (hit[WIN_FW]) begin
      raw_dst = DST_MEM;
      raw_off = win_off[WIN_FW];
    end else if (hit[WIN_MEM]) begin
      raw_dst = DST_MEM;
      raw_off = win_off[WIN_MEM];
    end else if (hit[WIN_IO]) begin
      raw_dst = DST_IO;
      raw_off = win_off[WIN_IO];
    end else if (hit[WIN_HC]) begin
      raw_dst = DST_HC;
      raw_off = win_off[WIN_HC];
    end else if (hit[WIN_LOC]) begin
      raw_dst = DST_LOCAL;
      raw_off = win_off[WIN_LOC];
    end
  end

  assign reg_win   = (raw_dst == DST_LOCAL) || (raw_dst == DST_HC);
  assign bad_shape = reg_win && ((size != SZ_4B) || (addr[1:0] != 2'b00));

  always_comb begin
    dst = bad_shape ? DST_NONE : raw_dst;
    off = bad_shape ? '0 : raw_off;
  end
endmodule

// File: rtl/opbr_irq_bank.sv
module opbr_irq_bank
  import opbr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LOC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    irq_raw,
  input  logic             acc_en,
  input  logic             acc_write,
  input  logic [LOC_W-1:0] acc_off,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    rd_data,
  output logic             irq_out
);
  logic [DW-1:0] stat_q, stat_d;
  logic [DW-1:0] mask_q, mask_d;
  logic [DW-1:0] pol_q,  pol_d;
  logic [DW-1:0] raw_q;
  logic          wr_stat, wr_mask, wr_pol;
  logic [DW-1:0] clr_bits;

  assign wr_stat = acc_en && acc_write && (acc_off == LOC_W'(OFS_STAT));
  assign wr_mask = acc_en && acc_write && (acc_off == LOC_W'(OFS_MASK));
  assign wr_pol  = acc_en && acc_write && (acc_off == LOC_W'(OFS_POL));

  // next-state
  always_comb begin
    clr_bits = wr_stat ? acc_wdata : '0;
    stat_d   = (stat_q & ~clr_bits) | (raw_q ^ pol_q);
    mask_d   = wr_mask ? acc_wdata : mask_q;
    pol_d    = wr_pol  ? acc_wdata : pol_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      raw_q  <= '0;
    end else begin
      stat_q <= stat_d;
      raw_q  <= irq_raw;
      if (wr_mask) mask_q <= mask_d;
      if (wr_pol)  pol_q  <= pol_d;
    end
  end

  // read mux
  always_comb begin
    unique case (acc_off)
      LOC_W'(OFS_STAT): rd_data = stat_q;
      LOC_W'(OFS_MASK): rd_data = mask_q;
      LOC_W'(OFS_POL):  rd_data = pol_q;
      LOC_W'(OFS_RAW):  rd_data = raw_q;
      default:          rd_data = '1;
    endcase
  end

  assign irq_out = |(stat_q & mask_q);
endmodule

// File: rtl/opbr_xfer_ctrl.sv
module opbr_xfer_ctrl
  import opbr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFF_W = 28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [DW-1:0]         req_wdata,
  input  opbr_dst_e             dec_dst,
  input  logic [OFF_W-1:0]      dec_off,
  input  logic [DW-1:0]         loc_rdata,
  output logic                  loc_en,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [DW-1:0]         rsp_rdata,
  output logic [NUM_FWD-1:0]    tgt_sel,
  output logic                  tgt_write,
  output logic [1:0]            tgt_size,
  output logic [OFF_W-1:0]      tgt_offset,
  output logic [DW-1:0]         tgt_wdata,
  input  logic [NUM_FWD-1:0]    tgt_ack,
  input  logic [NUM_FWD-1:0]    tgt_err,
  input  logic [NUM_FWD*DW-1:0] tgt_rdata
);
  opbr_state_e         st_q, st_d;
  logic [NUM_FWD-1:0]  sel_q, sel_d;
  logic                live_q;
  logic                wr_q;
  logic [1:0]          size_q;
  logic [OFF_W-1:0]    off_q;
  logic [DW-1:0]       wdata_q;
  logic                err_q, err_d;
  logic [DW-1:0]       data_q, data_d;
  logic                accept, done, rsp_load;
  logic [DW-1:0]       lane_data;
  logic [NUM_FWD-1:0]  hit_ack;

  assign req_ready = live_q && (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign loc_en    = accept && (dec_dst == DST_LOCAL);
  assign hit_ack   = tgt_ack & sel_q;
  assign done      = (st_q == ST_FWD) && (|hit_ack);

  always_comb begin
    lane_data = '0;
    for (int i = 0; i < NUM_FWD; i++) begin
      if (sel_q[i]) lane_data = lane_data | tgt_rdata[i*DW +: DW];
    end
  end

  // next-state
  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    err_d    = err_q;
    data_d   = data_q;
    rsp_load = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (dec_dst)
            DST_HC:  begin sel_d = NUM_FWD'(1) << LANE_HC;  st_d = ST_FWD; end
            DST_IO:  begin sel_d = NUM_FWD'(1) << LANE_IO;  st_d = ST_FWD; end
            DST_MEM: begin sel_d = NUM_FWD'(1) << LANE_MEM; st_d = ST_FWD; end
            DST_LOCAL: begin
              rsp_load = 1'b1;
              err_d    = 1'b0;
              data_d   = req_write ? '0 : loc_rdata;
              st_d     = ST_RESP;
            end
            default: begin
              rsp_load = 1'b1;
              err_d    = 1'b1;
              data_d   = '1;
              st_d     = ST_RESP;
            end
          endcase
        end
      end
      ST_FWD: begin
        if (done) begin
          rsp_load = 1'b1;
          err_d    = |(tgt_err & sel_q);
          data_d   = lane_data;
          sel_d    = '0;
          st_d     = ST_RESP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      live_q  <= 1'b0;
      wr_q    <= 1'b0;
      size_q  <= '0;
      off_q   <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      live_q <= 1'b1;
      if (accept) begin
        wr_q    <= req_write;
        size_q  <= req_size;
        off_q   <= dec_off;
        wdata_q <= req_wdata;
      end
      if (rsp_load) begin
        err_q  <= err_d;
        data_q <= data_d;
      end
    end
  end

  assign rsp_valid  = (st_q == ST_RESP);
  assign rsp_err    = err_q;
  assign rsp_rdata  = data_q;
  assign tgt_sel    = sel_q;
  assign tgt_write  = wr_q;
  assign tgt_size   = size_q;
  assign tgt_offset = off_q;
  assign tgt_wdata  = wdata_q;
endmodule

// File: rtl/opb_window_router.sv
module opb_window_router
  import opbr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int OFF_W = 28
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [AW-1:0]         req_addr,
  input  logic [DW-1:0]         req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [DW-1:0]         rsp_rdata,
  output logic [NUM_FWD-1:0]    tgt_sel,
  output logic                  tgt_write,
  output logic [1:0]            tgt_size,
  output logic [OFF_W-1:0]      tgt_offset,
  output logic [DW-1:0]         tgt_wdata,
  input  logic [NUM_FWD-1:0]    tgt_ack,
  input  logic [NUM_FWD-1:0]    tgt_err,
  input  logic [NUM_FWD*DW-1:0] tgt_rdata,
  input  logic [DW-1:0]         irq_raw,
  output logic                  irq_out
);
  localparam int LOC_W = 13;

  logic             rst_n_s;
  opbr_dst_e        dec_dst;
  logic [OFF_W-1:0] dec_off;
  logic [DW-1:0]    loc_rdata;
  logic             loc_en;

  opbr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  opbr_decode #(.AW(AW), .OFF_W(OFF_W)) u_dec (
    .addr (req_addr),
    .size (req_size),
    .dst  (dec_dst),
    .off  (dec_off)
  );

  opbr_irq_bank #(.DW(DW), .LOC_W(LOC_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .irq_raw   (irq_raw),
    .acc_en    (loc_en),
    .acc_write (req_write),
    .acc_off   (dec_off[LOC_W-1:0]),
    .acc_wdata (req_wdata),
    .rd_data   (loc_rdata),
    .irq_out   (irq_out)
  );

  opbr_xfer_ctrl #(.DW(DW), .OFF_W(OFF_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .dec_dst    (dec_dst),
    .dec_off    (dec_off),
    .loc_rdata  (loc_rdata),
    .loc_en     (loc_en),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .tgt_sel    (tgt_sel),
    .tgt_write  (tgt_write),
    .tgt_size   (tgt_size),
    .tgt_offset (tgt_offset),
    .tgt_wdata  (tgt_wdata),
    .tgt_ack    (tgt_ack),
    .tgt_err    (tgt_err),
    .tgt_rdata  (tgt_rdata)
  );
endmodule

// File: rtl/opbr_router_chk.sv
module opbr_router_chk #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int OFF_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_size,
  input logic [AW-1:0]    req_addr,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [DW-1:0]    rsp_rdata,
  input logic [2:0]       tgt_sel,
  input logic [2:0]       tgt_ack,
  input logic [OFF_W-1:0] tgt_offset
);
  logic acc;
  assign acc = req_valid && req_ready;

  a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  a_r5_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r5_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || (tgt_sel != 3'b000)) |-> !req_ready);

  a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((tgt_sel != 3'b000) && ((tgt_ack & tgt_sel) == 3'b000))
      |=> ((tgt_sel == $past(tgt_sel)) && $stable(tgt_offset)));

  a_r3_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_addr < 32'hC001_0000))
      |=> (rsp_valid && rsp_err && (rsp_rdata == 32'hFFFF_FFFF) && (tgt_sel == 3'b000)));

  a_r11_local_lat: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_addr[31:13] == 19'h60008) && (req_size == 2'd2) && (req_addr[1:0] == 2'b00))
      |=> (rsp_valid && !rsp_err));
endmodule

bind opb_window_router opbr_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_size   (req_size),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_rdata  (rsp_rdata),
  .tgt_sel    (tgt_sel),
  .tgt_ack    (tgt_ack),
  .tgt_offset (tgt_offset)
);

// File: tb/opb_window_router_tb_top.sv
`timescale 1ns/1ps
module opb_window_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [2:0]  tgt_sel;
  logic        tgt_write;
  logic [1:0]  tgt_size;
  logic [27:0] tgt_offset;
  logic [31:0] tgt_wdata;
  logic [2:0]  tgt_ack = '0;
  logic [2:0]  tgt_err = '0;
  logic [95:0] tgt_rdata = '0;
  logic [31:0] irq_raw = '0;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  opb_window_router dut_i (.*);

  // scoreboard queues
  bit          exp_err_q[$];
  logic [31:0] exp_dat_q[$];
  string       exp_tag_q[$];
  logic [2:0]  f_sel_q[$];
  logic [27:0] f_off_q[$];
  bit          f_wr_q[$];
  logic [1:0]  f_sz_q[$];
  logic [31:0] f_wd_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_pat(input int lane, input logic [27:0] off);
    return {1'b0, 3'(1 << lane), off};
  endfunction

  // driver
  task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, input bit eerr, input logic [31:0] edat,
                        input bit is_local, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_err_q.push_back(eerr);
    exp_dat_q.push_back(edat);
    exp_tag_q.push_back(tag);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (is_local) chk(rsp_valid === 1'b1, {tag, " R11 latency"}, 32'(rsp_valid), 32'd1);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic loc_rd(input logic [12:0] off, input logic [31:0] exp, input string tag);
    access(1'b0, 2'd2, 32'hC001_0000 + 32'(off), '0, 1'b0, exp, 1'b1, tag);
  endtask

  task automatic loc_wr(input logic [12:0] off, input logic [31:0] wd, input string tag);
    access(1'b1, 2'd2, 32'hC001_0000 + 32'(off), wd, 1'b0, '0, 1'b1, tag);
  endtask

  task automatic bad(input bit wr, input logic [1:0] sz, input logic [31:0] addr, input string tag);
    access(wr, sz, addr, 32'h1234_5678, 1'b1, 32'hFFFF_FFFF, 1'b1, tag);
  endtask

  task automatic fwd(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                     input logic [31:0] wd, input int lane, input logic [27:0] off, input string tag);
    f_sel_q.push_back(3'(1 << lane));
    f_off_q.push_back(off);
    f_wr_q.push_back(wr);
    f_sz_q.push_back(sz);
    f_wd_q.push_back(wd);
    access(wr, sz, addr, wd, off == 28'hBAD, lane_pat(lane, off), 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid === 1'b1) begin
        if (exp_err_q.size() == 0) begin
          chk(1'b0, "R5 unexpected response", rsp_rdata, '0);
        end else begin
          bit e; logic [31:0] d; string t;
          e = exp_err_q.pop_front(); d = exp_dat_q.pop_front(); t = exp_tag_q.pop_front();
          chk(rsp_err === e, {t, " err"}, 32'(rsp_err), 32'(e));
          chk(rsp_rdata === d, {t, " data"}, rsp_rdata, d);
        end
      end
    end
  end

  // target responder stub
  initial begin
    forever begin
      @(negedge clk);
      if (tgt_sel !== 3'b000) begin
        logic [2:0] s; logic [27:0] o;
        s = tgt_sel; o = tgt_offset;
        if (f_sel_q.size() == 0) begin
          chk(1'b0, "R4 unexpected forward", 32'(s), 32'd0);
        end else begin
          logic [2:0] es; logic [27:0] eo; bit ew; logic [1:0] ez; logic [31:0] ed;
          es = f_sel_q.pop_front(); eo = f_off_q.pop_front(); ew = f_wr_q.pop_front();
          ez = f_sz_q.pop_front(); ed = f_wd_q.pop_front();
          chk(s === es, "R1/R2 target select", 32'(s), 32'(es));
          chk(o === eo, "R1/R2 target offset", 32'(o), 32'(eo));
          chk(tgt_write === ew && tgt_size === ez && (!ew || tgt_wdata === ed),
              "R1 forwarded fields", tgt_wdata, ed);
        end
        for (int i = 0; i < 3; i++) tgt_rdata[i*32 +: 32] = lane_pat(i, o);
        for (int k = 0; k < 2; k++) begin
          tgt_ack = ~s; tgt_err = ~s;   // R5: acks from unselected lanes
          @(negedge clk);
          chk(tgt_sel === s && tgt_offset === o, "R5 hold until ack", 32'(tgt_sel), 32'(s));
        end
        tgt_ack = s;
        tgt_err = (o == 28'hBAD) ? s : 3'b000;
        @(negedge clk);
        tgt_ack = '0; tgt_err = '0;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R5 actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(req_ready === 1'b1, "R12 ready", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R12 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(tgt_sel === 3'b000, "R12 tgt_sel", 32'(tgt_sel), 32'd0);
    chk(irq_out === 1'b0, "R12 irq_out", 32'(irq_out), 32'd0);

    // R6 reset values
    loc_rd(13'h054, 32'h0, "R6 mask reset");
    loc_rd(13'h058, 32'h0, "R6 pol reset");
    loc_rd(13'h050, 32'h0, "R8 stat reset");

    // R3 unmapped
    bad(1'b0, 2'd2, 32'h0000_1000, "R3 low hole");
    bad(1'b0, 2'd2, 32'hC001_3000, "R3 after hc window");
    bad(1'b1, 2'd0, 32'hD000_0000, "R3 write below io");
    bad(1'b0, 2'd0, 32'hD002_0000, "R3 past io end");

    // R10 unimplemented local offsets
    loc_rd(13'h100, 32'hFFFF_FFFF, "R10 unimpl read");
    loc_wr(13'h060, 32'hFFFF_FFFF, "R10 unimpl write");
    loc_rd(13'h054, 32'h0, "R10 mask untouched");

    // R6 mask and polarity
    loc_wr(13'h054, 32'h0000_0801, "R6 mask write");
    loc_rd(13'h054, 32'h0000_0801, "R6 mask readback");
    loc_wr(13'h058, 32'h0000_0002, "R6 pol write");
    loc_rd(13'h058, 32'h0000_0002, "R6 pol readback");
    chk(irq_out === 1'b0, "R9 unmasked bit stays quiet", 32'(irq_out), 32'd0);

    // R7, R8, R9 with host-controller line (bit 11)
    loc_rd(13'h05C, 32'h0, "R7 raw idle");
    @(negedge clk); irq_raw = 32'h0000_0800;
    repeat (3) @(negedge clk);
    chk(irq_out === 1'b1, "R9 hc line raises irq", 32'(irq_out), 32'd1);
    loc_rd(13'h05C, 32'h0000_0800, "R7 raw sampled");
    loc_rd(13'h050, 32'h0000_0802, "R8 status set");
    loc_wr(13'h05C, 32'h0, "R7 raw write");
    loc_rd(13'h05C, 32'h0000_0800, "R7 raw write ignored");
    @(negedge clk); irq_raw = 32'h0;
    repeat (3) @(negedge clk);
    loc_rd(13'h050, 32'h0000_0802, "R8 sticky after line drop");
    chk(irq_out === 1'b1, "R9 sticky irq", 32'(irq_out), 32'd1);
    loc_wr(13'h050, 32'h0000_0800, "R8 w1c");
    chk(irq_out === 1'b0, "R9 irq after clear", 32'(irq_out), 32'd0);
    loc_rd(13'h050, 32'h0000_0002, "R8 partial clear");
    loc_wr(13'h050, 32'h0000_0002, "R8 w1c active cond");
    loc_rd(13'h050, 32'h0000_0002, "R8 cond persists");
    loc_wr(13'h058, 32'h0, "R6 pol clear");
    loc_wr(13'h050, 32'h0000_0002, "R8 w1c after pol");
    loc_rd(13'h050, 32'h0, "R8 cleared");

    // R8/R9 sticky through polarity flip on masked bit 0
    @(negedge clk); irq_raw = 32'h0000_0001;
    repeat (3) @(negedge clk);
    chk(irq_out === 1'b1, "R9 bit0 irq", 32'(irq_out), 32'd1);
    loc_wr(13'h058, 32'h0000_0001, "R8 pol cancels");
    repeat (2) @(negedge clk);
    chk(irq_out === 1'b1, "R8 stays until cleared", 32'(irq_out), 32'd1);
    loc_wr(13'h050, 32'h0000_0001, "R8 w1c bit0");
    chk(irq_out === 1'b0, "R9 bit0 cleared", 32'(irq_out), 32'd0);

    // R4 shape rules
    bad(1'b0, 2'd1, 32'hC001_2004, "R4 hc 2-byte");
    bad(1'b0, 2'd2, 32'hC001_0052, "R4 local misaligned");
    bad(1'b1, 2'd0, 32'hC001_0054, "R4 local 1-byte write");
    loc_rd(13'h054, 32'h0000_0801, "R4 mask unchanged");

    // R1 forwarding
    fwd(1'b0, 2'd2, 32'hC001_2010, '0, 0, 28'h10, "R1 hc read");
    fwd(1'b0, 2'd2, 32'hC001_2FFC, '0, 0, 28'hFFC, "R1 hc top");
    fwd(1'b1, 2'd0, 32'hD001_0123, 32'h0000_00A5, 1, 28'h123, "R1 io write");
    fwd(1'b0, 2'd0, 32'hD001_FFFF, '0, 1, 28'hFFFF, "R1 io top byte");
    fwd(1'b0, 2'd0, 32'hD001_0000, '0, 1, 28'h0, "R1 io base");

    // R2 memory and firmware alias
    fwd(1'b0, 2'd2, 32'hE001_0040, '0, 2, 28'h40, "R2 mem read");
    fwd(1'b1, 2'd2, 32'hF000_0040, 32'hCAFE_F00D, 2, 28'h40, "R2 fw write");
    fwd(1'b0, 2'd2, 32'hEFFF_FFFC, '0, 2, 28'hFFEF_FFC, "R2 mem below overlap");
    fwd(1'b0, 2'd2, 32'hF000_0020, '0, 2, 28'h20, "R2 overlap fw wins");
    fwd(1'b0, 2'd2, 32'hFFFF_FFFC, '0, 2, 28'hFFF_FFFC, "R2 fw top");

    // R5 target error
    fwd(1'b0, 2'd0, 32'hD001_0BAD, '0, 1, 28'hBAD, "R5 target error");

    repeat (6) @(negedge clk);
    chk(exp_err_q.size() == 0, "R5 all responses seen", 32'(exp_err_q.size()), 32'd0);
    chk(f_sel_q.size() == 0, "R1 all forwards seen", 32'(f_sel_q.size()), 32'd0);
    finished = 1;
    summary();
    $finish;
  end
endmodule